// File: doc/BRIEF.md
# Tile-Fetch CHR Bank Latch

This block picks the 1 KiB pattern-memory bank number for each of the eight CHR slots of a picture processor. In its latched mode, the two 4 KiB pattern-table halves each follow a one-bit latch. The latch flips as a side effect of the picture processor fetching one of two marker tiles. A fetch of tile 0xFD resets a half's latch to offset 0, and a fetch of tile 0xFE sets it to offset 2. The latch offset selects which CPU-written bank register feeds that half. That register value is shifted down by two to form a 4 KiB bank, and the four 1 KiB slots of the half are then numbered from it.

A second mode drives the eight slots straight from eight 1 KiB bank registers. When banking is switched off, the block raises a bypass flag so that an external 8 KiB bank source is used instead. The CPU writes registers by a 4-bit index. Indices 8 and up belong to nametable mapping, which lives outside this block.

Top module: `chr_tile_latch`

## Requirements
- R1: After synchronous reset, bank register k (k = 0..7) holds k and both latches hold 0, so in latched mode the slot output reads slot k = k (packed 0x0706050403020100, slot k at bits 8k+7..8k).
- R2: With bank_en = 1 and fine_en = 1 (direct mode), slot k equals bank register k.
- R3: With bank_en = 1 and fine_en = 0 (latched mode), slots 0-3 use register (0 + 2·latch_lo) and slots 4-7 use register (4 + 2·latch_hi). Slot k outputs (reg >> 2)·4 + (k mod 4).
- R4: A strobed fetch whose address ANDed with 0x2FF0 equals 0x0FD0 clears the latch of the half selected by address bit 12 (0 = lower, 1 = upper).
- R5: A strobed fetch whose address ANDed with 0x2FF0 equals 0x0FE0 sets the latch of the half selected by address bit 12 to offset 2.
- R6: Latches change only on a cycle with ppu_strobe high. Addresses that do not match, including those with bit 13 set, leave the latches unchanged.
- R7: Fetches made while not in latched mode (direct mode or bypass) do not change the latches.
- R8: With bank_en = 0 the block outputs bypass = 1 and all slot outputs 0. Otherwise bypass = 0.
- R9: CPU writes with index 8 to 15 do not change any of the eight bank registers.
- R10: Outputs are registered. A register write or latching fetch on clock edge N is visible at the outputs after edge N+1, and not before.
- R11: Asserting reset mid-operation returns both latches to 0 as well as the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_en | input | 1 | 1: block supplies slot banks; 0: bypass |
| fine_en | input | 1 | 1: direct 1 KiB mode; 0: latched 4 KiB mode |
| cpu_wr | input | 1 | Bank register write strobe |
| cpu_idx | input | IW (4) | Bank register index |
| cpu_data | input | BW (8) | Bank register write data |
| ppu_strobe | input | 1 | Picture processor address valid |
| ppu_addr | input | AW (14) | Picture processor address |
| slot_bank | output | NSLOT*BW (64) | 1 KiB bank per slot, slot k at bits 8k+7..8k |
| bypass | output | 1 | External 8 KiB bank source in use |

## Verification
The bench targets the match mask. Because address bit 12 is excluded from the mask, a design that includes it would never latch the upper half. Because bit 13 is included, a design that drops it would latch on nametable fetches at 0x2FE0. The bench also latches and un-latches each half while writing the unselected register in between, to catch a design that swaps halves or ignores the offset. A fetch made in direct and bypass modes must leave the latches untouched; a design that gates the latch only on strobe would show the wrong bank on return to latched mode. Writes to indices 9 and 15 must not alias onto registers 1 and 7 through truncated index decode, and the one-cycle output latency is checked on both sides of the expected edge.

// File: rtl/chr_latch_pkg.sv
package chr_latch_pkg;
  // Compare mask for a marker-tile fetch: bits 13 and 11..4 take part; bit 12 picks the half.
  localparam logic [13:0] TILE_MASK = 14'h2FF0;
  localparam logic [13:0] TILE_CLR  = 14'h0FD0;  // marker tile that selects offset 0
  localparam logic [13:0] TILE_SET  = 14'h0FE0;  // marker tile that selects offset 2
  localparam int          LATCH_STEP = 2;        // register offset selected by a set latch
  localparam int          HALF_BIT   = 12;       // address bit choosing the pattern-table half
endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs #(
  parameter int NSLOT = 8,
  parameter int BW    = 8,
  parameter int IW    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [IW-1:0]      idx,
  input  logic [BW-1:0]      data,
  output logic [NSLOT*BW-1:0] regs_q
);
  // Only the slot registers live here; higher indices address nametable state elsewhere.
  for (genvar k = 0; k < NSLOT; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[k*BW +: BW] <= BW'(k);
      else if (wr && (idx == IW'(k)))
        regs_q[k*BW +: BW] <= data;
    end
  end

  // R9: indices past the slot registers leave every slot register untouched
  assert_high_idx_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (wr && (idx >= IW'(NSLOT))) |=> $stable(regs_q));
endmodule

// File: rtl/chr_fetch_latch.sv
module chr_fetch_latch
  import chr_latch_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          strobe,
  input  logic [AW-1:0] addr,
  output logic [1:0]    sel_q
);
  logic hit_clr, hit_set, half;

  assign hit_clr = ((addr & AW'(TILE_MASK)) == AW'(TILE_CLR));
  assign hit_set = ((addr & AW'(TILE_MASK)) == AW'(TILE_SET));
  assign half    = addr[HALF_BIT];

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst)
        sel_q[h] <= 1'b0;
      else if (active && strobe && (half == h[0])) begin
        if (hit_clr)      sel_q[h] <= 1'b0;
        else if (hit_set) sel_q[h] <= 1'b1;
      end
    end
  end

  assert_clr_lo_R4: assert property (@(posedge clk) disable iff (rst)
    (active && strobe && hit_clr && !half) |=> !sel_q[0]);
  assert_clr_hi_R4: assert property (@(posedge clk) disable iff (rst)
    (active && strobe && hit_clr && half) |=> !sel_q[1]);
  assert_set_lo_R5: assert property (@(posedge clk) disable iff (rst)
    (active && strobe && hit_set && !half) |=> sel_q[0]);
  assert_set_hi_R5: assert property (@(posedge clk) disable iff (rst)
    (active && strobe && hit_set && half) |=> sel_q[1]);
  assert_no_strobe_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(sel_q));
  assert_inactive_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(sel_q));
endmodule

// File: rtl/chr_slot_map.sv
module chr_slot_map
  import chr_latch_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int BW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bank_en,
  input  logic                fine_en,
  input  logic [NSLOT*BW-1:0] regs,
  input  logic [1:0]          sel,
  output logic [NSLOT*BW-1:0] slot_q,
  output logic                bypass_q
);
  localparam int HALF = NSLOT / 2;
  localparam int OFFW = $clog2(HALF);
  localparam int RIW  = $clog2(NSLOT);

  logic [BW-1:0] rarr [NSLOT];
  for (genvar k = 0; k < NSLOT; k++) begin : g_unpack
    assign rarr[k] = regs[k*BW +: BW];
  end

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    localparam int H   = k / HALF;
    localparam int OFF = k % HALF;
    logic [RIW-1:0] ridx;
    logic [BW-1:0]  lat_val;
    logic [BW-1:0]  next_val;

    assign ridx    = RIW'(H * HALF) + (sel[H] ? RIW'(LATCH_STEP) : '0);
    assign lat_val = {rarr[ridx][BW-1:OFFW], OFFW'(OFF)};

    always_comb begin
      if (!bank_en)     next_val = '0;
      else if (fine_en) next_val = rarr[k];
      else              next_val = lat_val;
    end

    always_ff @(posedge clk) begin
      if (rst) slot_q[k*BW +: BW] <= BW'(k);
      else     slot_q[k*BW +: BW] <= next_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bypass_q <= 1'b0;
    else     bypass_q <= !bank_en;
  end

  assert_direct_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (bank_en && fine_en) |=> (slot_q == $past(regs)));
  assert_bypass_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !bank_en |=> (bypass_q && (slot_q == '0)));
  assert_bypass_low_R8: assert property (@(posedge clk) disable iff (rst)
    bank_en |=> !bypass_q);
endmodule

// File: rtl/chr_tile_latch.sv
module chr_tile_latch #(
  parameter int AW    = 14,
  parameter int BW    = 8,
  parameter int NSLOT = 8,
  parameter int IW    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bank_en,
  input  logic                fine_en,
  input  logic                cpu_wr,
  input  logic [IW-1:0]       cpu_idx,
  input  logic [BW-1:0]       cpu_data,
  input  logic                ppu_strobe,
  input  logic [AW-1:0]       ppu_addr,
  output logic [NSLOT*BW-1:0] slot_bank,
  output logic                bypass
);
  logic [NSLOT*BW-1:0] regs;
  logic [1:0]          sel;
  logic                latch_active;

  assign latch_active = bank_en && !fine_en;

  chr_bank_regs #(.NSLOT(NSLOT), .BW(BW), .IW(IW)) u_regs (
    .clk(clk), .rst(rst), .wr(cpu_wr), .idx(cpu_idx), .data(cpu_data), .regs_q(regs)
  );

  chr_fetch_latch #(.AW(AW)) u_latch (
    .clk(clk), .rst(rst), .active(latch_active), .strobe(ppu_strobe),
    .addr(ppu_addr), .sel_q(sel)
  );

  chr_slot_map #(.NSLOT(NSLOT), .BW(BW)) u_map (
    .clk(clk), .rst(rst), .bank_en(bank_en), .fine_en(fine_en), .regs(regs),
    .sel(sel), .slot_q(slot_bank), .bypass_q(bypass)
  );
endmodule

// File: tb/chr_tile_latch_tb.sv
`timescale 1ns/1ps
module chr_tile_latch_tb;
  logic        clk = 1'b0;
  logic        rst, bank_en, fine_en, cpu_wr, ppu_strobe;
  logic [3:0]  cpu_idx;
  logic [7:0]  cpu_data;
  logic [13:0] ppu_addr;
  logic [63:0] slot_bank;
  logic        bypass;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chr_tile_latch u_dut (
    .clk(clk), .rst(rst), .bank_en(bank_en), .fine_en(fine_en), .cpu_wr(cpu_wr),
    .cpu_idx(cpu_idx), .cpu_data(cpu_data), .ppu_strobe(ppu_strobe),
    .ppu_addr(ppu_addr), .slot_bank(slot_bank), .bypass(bypass)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        en, fine, wr;
    logic [3:0]  idx;
    logic [7:0]  data;
    logic        stb;
    logic [13:0] addr;
    logic [63:0] exp;
    logic        byp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{8'd3, 1'b1,1'b0,1'b1, 4'd2, 8'h28, 1'b0, 14'h0000, 64'h0706050403020100, 1'b0}, // R3 unselected reg
    '{8'd5, 1'b1,1'b0,1'b0, 4'd0, 8'h00, 1'b1, 14'h0FE0, 64'h070605042B2A2928, 1'b0}, // R5 lower
    '{8'd3, 1'b1,1'b0,1'b1, 4'd6, 8'h40, 1'b0, 14'h0000, 64'h070605042B2A2928, 1'b0}, // R3
    '{8'd5, 1'b1,1'b0,1'b0, 4'd0, 8'h00, 1'b1, 14'h1FE8, 64'h434241402B2A2928, 1'b0}, // R5 upper
    '{8'd4, 1'b1,1'b0,1'b0, 4'd0, 8'h00, 1'b1, 14'h0FD5, 64'h4342414003020100, 1'b0}, // R4 lower
    '{8'd6, 1'b1,1'b0,1'b0, 4'd0, 8'h00, 1'b1, 14'h2FE0, 64'h4342414003020100, 1'b0}, // R6 bit13
    '{8'd6, 1'b1,1'b0,1'b0, 4'd0, 8'h00, 1'b1, 14'h0FC0, 64'h4342414003020100, 1'b0}, // R6 other tile
    '{8'd3, 1'b1,1'b0,1'b1, 4'd0, 8'h13, 1'b0, 14'h0000, 64'h4342414013121110, 1'b0}, // R3 shift
    '{8'd9, 1'b1,1'b0,1'b1, 4'd9, 8'hFF, 1'b0, 14'h0000, 64'h4342414013121110, 1'b0}, // R9
    '{8'd9, 1'b1,1'b0,1'b1, 4'd15,8'hFF, 1'b0, 14'h0000, 64'h4342414013121110, 1'b0}, // R9
    '{8'd4, 1'b1,1'b0,1'b0, 4'd0, 8'h00, 1'b1, 14'h1FD0, 64'h0706050413121110, 1'b0}, // R4 upper
    '{8'd6, 1'b1,1'b0,1'b0, 4'd0, 8'h00, 1'b0, 14'h0FE0, 64'h0706050413121110, 1'b0}, // R6 no strobe
    '{8'd2, 1'b1,1'b1,1'b0, 4'd0, 8'h00, 1'b0, 14'h0000, 64'h0740050403280113, 1'b0}, // R2
    '{8'd7, 1'b1,1'b1,1'b0, 4'd0, 8'h00, 1'b1, 14'h0FE0, 64'h0740050403280113, 1'b0}, // R7 direct
    '{8'd7, 1'b1,1'b0,1'b0, 4'd0, 8'h00, 1'b0, 14'h0000, 64'h0706050413121110, 1'b0}, // R7
    '{8'd8, 1'b0,1'b0,1'b0, 4'd0, 8'h00, 1'b1, 14'h1FE0, 64'h0000000000000000, 1'b1}, // R8
    '{8'd7, 1'b1,1'b0,1'b0, 4'd0, 8'h00, 1'b0, 14'h0000, 64'h0706050413121110, 1'b0}  // R7 after bypass
  };

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    bank_en = v.en; fine_en = v.fine; cpu_wr = v.wr; cpu_idx = v.idx;
    cpu_data = v.data; ppu_strobe = v.stb; ppu_addr = v.addr;
    @(posedge clk);
    @(negedge clk);
    cpu_wr = 1'b0; ppu_strobe = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; bank_en = 1'b1; fine_en = 1'b0; cpu_wr = 1'b0; cpu_idx = '0;
    cpu_data = '0; ppu_strobe = 1'b0; ppu_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); @(negedge clk);
    // R1: reset contents through latched mode
    check("R1 reset slots", slot_bank, 64'h0706050403020100);
    check("R1 reset bypass", {63'd0, bypass}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), slot_bank, VEC[i].exp);
      check($sformatf("R%0d vector %0d bypass", VEC[i].req, i), {63'd0, bypass}, {63'd0, VEC[i].byp});
    end

    // R10: one-cycle registered latency in direct mode
    @(negedge clk);
    fine_en = 1'b1; bank_en = 1'b1;
    @(posedge clk); @(negedge clk);
    cpu_wr = 1'b1; cpu_idx = 4'd1; cpu_data = 8'h55;
    @(posedge clk); @(negedge clk);
    cpu_wr = 1'b0;
    check("R10 before latency", slot_bank[15:8], 64'h01);
    @(posedge clk); @(negedge clk);
    check("R10 after latency", slot_bank[15:8], 64'h55);

    // R11: latch set, then reset mid-run
    fine_en = 1'b0;
    ppu_strobe = 1'b1; ppu_addr = 14'h0FE3;
    @(posedge clk); @(negedge clk);
    ppu_strobe = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R11 latch set before reset", slot_bank[31:0], 64'h2B2A2928);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    cpu_wr = 1'b1; cpu_idx = 4'd2; cpu_data = 8'h28;
    @(posedge clk); @(negedge clk);
    cpu_wr = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R11 latch cleared by reset", slot_bank, 64'h0706050403020100);

    finish_run();
  end
endmodule